// File: doc/BRIEF.md
# Posted Write Fault Recorder

This block watches posted writes on a device bus and records the first failure it sees. A write is tracked from the cycle it is issued until it completes. It can fail in three ways. The completion can carry an error acknowledge. The completion can fail to arrive within a fixed 12.8 microsecond window. Or the bus can report a late error after the write has already finished. The block keeps one outstanding write at a time. Issuing a new write replaces the one being tracked.

When a failure occurs, the block latches a 32-bit status word and the physical address of the faulting write. Software reads both through a two-register port, and an interrupt stays high while a fault is logged. Later faults do not overwrite the logged one. They only set a sticky multiple-error flag. A write of any value to the status register clears the log and drops the interrupt.

Top module: `wfault_recorder`

## Requirements
- R1: With `reg_sel`=0, `reg_rdata` returns the status word. Bit 31 is the error summary and is set exactly when one of bit 30 (late error), bit 29 (timeout) or bit 28 (error acknowledge) is set. With `reg_sel`=1, `reg_rdata` returns the fault address, zero-extended to 32 bits.
- R2: A write issued by `wr_start` that gets neither `wr_ack` nor `wr_err_ack` by the TO_CYC-th rising edge after its issue edge is logged as a timeout. TO_CYC is CLK_HZ*128/10^7, which is 640 at 50 MHz. The log takes bit 29, the write's address, its size in bits 27:25, its supervisor flag in bit 24, and sets address-valid in bit 17. A completion arriving on that TO_CYC-th edge still counts as a completion.
- R3: `wr_err_ack` while a write is outstanding logs bit 28 with that write's address, size and supervisor flag, and sets bit 17.
- R4: `late_err` logs bit 30 with the attributes of the most recently issued write. Bit 17 is set only if a write has been issued since reset. If none has, the address reads 0.
- R5: Bits 23:20 of the status word always read 0x8. Bits 16:0 always read 0.
- R6: A fault that arrives while bit 31 is set only sets bit 19 (multiple errors). All other status bits and the address stay as they were.
- R7: When several faults arrive in the same cycle with nothing logged, exactly one is recorded, with priority error acknowledge over timeout over late error, and bit 19 is set as well.
- R8: Bit 18 records the value of `rd_busy` in the cycle the fault was captured.
- R9: `reg_wr` with `reg_sel`=0 clears the status word to 0x00800000 and the address to 0 on the next edge. If a fault arrives in that same cycle, it is logged fresh, with bit 19 clear. `reg_wr` with `reg_sel`=1 changes nothing.
- R10: `irq` is high exactly when status bit 31 reads 1.
- R11: `wr_ack` ends tracking of the outstanding write, and no fault is logged for it. `wr_ack` or `wr_err_ack` with no write outstanding is ignored.
- R12: After reset, status reads 0x00800000, the address reads 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | A posted write is issued this cycle |
| wr_addr | input | ADDR_W | Physical address of the issued write |
| wr_size | input | 3 | Size code of the issued write |
| wr_super | input | 1 | Issued write was made in supervisor mode |
| wr_ack | input | 1 | Outstanding write completed normally |
| wr_err_ack | input | 1 | Outstanding write completed with an error acknowledge |
| late_err | input | 1 | Bus reports an error after a write has completed |
| rd_busy | input | 1 | A read is in progress |
| reg_sel | input | 1 | Register select: 0 status, 1 fault address |
| reg_wr | input | 1 | Register write strobe (the data value is irrelevant) |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | High while a fault is logged |

## Verification
Most internal faults show up at the register port one cycle after the edge where they happen. A wrong capture priority or a lost attribute appears in the first status read after a fault. A sticky flag that fails to hold shows up when a second fault overwrites the first fault's address. A timeout counter that is off by even one cycle only becomes visible at the TO_CYC-th edge after a write is issued. For that reason the bench checks both the edge just before the limit and the limit edge itself, and it compares the whole status word after every cycle against its own model.

// File: rtl/wfr_pkg.sv
package wfr_pkg;

    localparam logic [3:0] STAT_RESV = 4'h8;

    typedef struct packed {
        logic       err;
        logic       le;
        logic       to;
        logic       be;
        logic [2:0] size;
        logic       sup;
        logic       me;
        logic       rd;
        logic       fav;
    } flt_stat_t;

    typedef struct packed {
        logic [2:0] size;
        logic       sup;
    } wr_attr_t;

    function automatic logic [31:0] pack_stat(flt_stat_t s);
        return {s.err, s.le, s.to, s.be, s.size, s.sup, STAT_RESV,
                s.me, s.rd, s.fav, 17'b0};
    endfunction

endpackage

// File: rtl/wfr_tracker.sv
module wfr_tracker
    import wfr_pkg::*;
#(
    parameter int TO_CYC = 640,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  wr_attr_t          attr_i,
    input  logic              ack_i,
    input  logic              eack_i,
    output logic              be_o,
    output logic              to_o,
    output logic              have_o,
    output wr_attr_t          attr_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int CW = (TO_CYC < 2) ? 1 : $clog2(TO_CYC);

    typedef struct packed {
        logic              pend;
        logic [CW-1:0]     cnt;
        logic              have;
        wr_attr_t          attr;
        logic [ADDR_W-1:0] addr;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        be_o  = trk_q.pend && eack_i;
        to_o  = trk_q.pend && !eack_i && !ack_i && (trk_q.cnt == CW'(TO_CYC - 1));
        if (trk_q.pend && (eack_i || ack_i || to_o)) begin
            trk_d.pend = 1'b0;
        end else if (trk_q.pend) begin
            trk_d.cnt = trk_q.cnt + 1'b1;
        end
        if (start_i) begin
            trk_d.pend = 1'b1;
            trk_d.cnt  = '0;
            trk_d.have = 1'b1;
            trk_d.attr = attr_i;
            trk_d.addr = addr_i;
        end
        have_o = trk_q.have;
        attr_o = trk_q.attr;
        addr_o = trk_q.addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.pend |-> (trk_q.cnt < CW'(TO_CYC))); // R2

    AST_FAULT_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((be_o || to_o || (trk_q.pend && ack_i)) && !start_i) |=> !trk_q.pend); // R11

endmodule

// File: rtl/wfr_log.sv
module wfr_log
    import wfr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              be_i,
    input  logic              to_i,
    input  logic              le_i,
    input  logic              rd_i,
    input  logic              have_i,
    input  wr_attr_t          attr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              clr_i,
    output flt_stat_t         stat_o,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        flt_stat_t         s;
        logic [ADDR_W-1:0] addr;
    } log_t;

    log_t       log_d, log_q;
    logic [1:0] n_evt;

    always_comb begin
        log_d = clr_i ? '0 : log_q;
        n_evt = {1'b0, be_i} + {1'b0, to_i} + {1'b0, le_i};
        if (n_evt != 2'd0) begin
            if (log_d.s.err) begin
                log_d.s.me = 1'b1;
            end else begin
                log_d.s.err  = 1'b1;
                log_d.s.be   = be_i;
                log_d.s.to   = !be_i && to_i;
                log_d.s.le   = !be_i && !to_i && le_i;
                log_d.s.me   = (n_evt > 2'd1);
                log_d.s.size = attr_i.size;
                log_d.s.sup  = attr_i.sup;
                log_d.s.rd   = rd_i;
                log_d.s.fav  = have_i;
                log_d.addr   = have_i ? addr_i : '0;
            end
        end
        stat_o = log_q.s;
        addr_o = log_q.addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        log_q.s.err == (log_q.s.le || log_q.s.to || log_q.s.be)); // R1

    AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({log_q.s.le, log_q.s.to, log_q.s.be}) <= 1); // R7

    AST_KEEP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (log_q.s.err && !clr_i) |=> ($stable(log_q.addr) && log_q.s.err)); // R6

    AST_ME_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        log_q.s.me |-> log_q.s.err); // R6

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !be_i && !to_i && !le_i) |=> (!log_q.s.err && !log_q.s.me && log_q.addr == '0)); // R9

endmodule

// File: rtl/wfault_recorder.sv
module wfault_recorder
    import wfr_pkg::*;
#(
    parameter longint CLK_HZ = 50_000_000,
    parameter int     ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [2:0]        wr_size,
    input  logic              wr_super,
    input  logic              wr_ack,
    input  logic              wr_err_ack,
    input  logic              late_err,
    input  logic              rd_busy,
    input  logic              reg_sel,
    input  logic              reg_wr,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int TO_CYC = int'((CLK_HZ * 128) / 64'd10_000_000);

    wr_attr_t          new_attr, cur_attr;
    logic              be_evt, to_evt, have_wr, clr;
    logic [ADDR_W-1:0] cur_addr, flt_addr;
    flt_stat_t         stat;

    always_comb begin
        new_attr.size = wr_size;
        new_attr.sup  = wr_super;
        clr           = reg_wr && !reg_sel;
    end

    wfr_tracker #(.TO_CYC(TO_CYC), .ADDR_W(ADDR_W)) u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(wr_start),
        .addr_i (wr_addr),
        .attr_i (new_attr),
        .ack_i  (wr_ack),
        .eack_i (wr_err_ack),
        .be_o   (be_evt),
        .to_o   (to_evt),
        .have_o (have_wr),
        .attr_o (cur_attr),
        .addr_o (cur_addr)
    );

    wfr_log #(.ADDR_W(ADDR_W)) u_log (
        .clk   (clk),
        .rst_n (rst_n),
        .be_i  (be_evt),
        .to_i  (to_evt),
        .le_i  (late_err),
        .rd_i  (rd_busy),
        .have_i(have_wr),
        .attr_i(cur_attr),
        .addr_i(cur_addr),
        .clr_i (clr),
        .stat_o(stat),
        .addr_o(flt_addr)
    );

    always_comb begin
        reg_rdata = reg_sel ? 32'(flt_addr) : pack_stat(stat);
        irq       = stat.err;
    end

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(be_evt || to_evt || late_err)); // R10

endmodule

// File: tb/tb_wfault_recorder.sv
module tb_wfault_recorder;
    localparam int TO = 640;

    logic        clk = 0, rst_n = 0;
    logic        wr_start = 0, wr_super = 0, wr_ack = 0, wr_err_ack = 0;
    logic        late_err = 0, rd_busy = 0, reg_sel = 0, reg_wr = 0;
    logic [31:0] wr_addr = 0;
    logic [2:0]  wr_size = 0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model state
    bit m_pend, m_have, m_sup;
    int m_cnt;
    logic [2:0] m_size;
    logic [31:0] m_addr;
    bit s_err, s_le, s_to, s_be, s_sup, s_me, s_rd, s_fav;
    logic [2:0] s_size;
    logic [31:0] s_addr;

    always #10 clk = ~clk;

    wfault_recorder dut (.*);

    function automatic logic [31:0] word(bit le, bit to, bit be, logic [2:0] sz,
                                         bit sup, bit me, bit rd, bit fav);
        return {(le | to | be), le, to, be, sz, sup, 4'h8, me, rd, fav, 17'b0};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        {s_err, s_le, s_to, s_be, s_sup, s_me, s_rd, s_fav} = '0;
        s_size = 0; s_addr = 0;
    endtask

    task automatic model_edge();
        bit be, to, le, clr;
        int n;
        clr = reg_wr && !reg_sel;
        be  = m_pend && wr_err_ack;
        to  = m_pend && !wr_err_ack && !wr_ack && (m_cnt == TO - 1);
        le  = late_err;
        n   = int'(be) + int'(to) + int'(le);
        if (!rst_n) begin
            model_clear(); m_pend = 0; m_have = 0; m_cnt = 0; m_size = 0; m_sup = 0; m_addr = 0;
            return;
        end
        if (clr) model_clear();
        if (n > 0) begin
            if (s_err) s_me = 1;
            else begin
                s_err = 1; s_be = be; s_to = !be && to; s_le = !be && !to && le;
                s_me = (n > 1); s_size = m_size; s_sup = m_sup; s_rd = rd_busy;
                s_fav = m_have; s_addr = m_have ? m_addr : 0;
            end
        end
        if (m_pend && (wr_err_ack || wr_ack || to)) m_pend = 0;
        else if (m_pend) m_cnt++;
        if (wr_start) begin
            m_pend = 1; m_cnt = 0; m_have = 1;
            m_size = wr_size; m_sup = wr_super; m_addr = wr_addr;
        end
    endtask

    task automatic cyc();
        logic sv;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        sv = reg_sel;
        reg_sel = 0; #1;
        chk("R1 model status", reg_rdata, word(s_le, s_to, s_be, s_size, s_sup, s_me, s_rd, s_fav));
        chk("R10 irq", {31'b0, irq}, {31'b0, s_err});
        reg_sel = 1; #1;
        chk("R1 model address", reg_rdata, s_addr);
        reg_sel = sv;
    endtask

    task automatic idle();
        wr_start = 0; wr_ack = 0; wr_err_ack = 0; late_err = 0; reg_wr = 0;
    endtask

    task automatic rd_stat(output logic [31:0] v);
        logic sv;
        sv = reg_sel; reg_sel = 0; #1; v = reg_rdata; reg_sel = sv;
    endtask

    task automatic rd_addr(output logic [31:0] v);
        logic sv;
        sv = reg_sel; reg_sel = 1; #1; v = reg_rdata; reg_sel = sv;
    endtask

    task automatic clear_log();
        reg_sel = 0; reg_wr = 1; cyc(); idle();
    endtask

    task automatic issue(logic [31:0] a, logic [2:0] sz, bit sup);
        wr_start = 1; wr_addr = a; wr_size = sz; wr_super = sup; cyc(); idle();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a;
        void'($urandom(32'h5EED_0042));
        idle();
        @(negedge clk); cyc(); cyc();
        rst_n = 1;
        cyc();
        // R12 / R5 reset state
        rd_stat(v); chk("R12 reset status", v, 32'h0080_0000);
        rd_addr(v); chk("R12 reset address", v, 0);
        chk("R12 reset irq", {31'b0, irq}, 0);

        // R4 late error with no write ever issued; R8 read-busy capture
        rd_busy = 1; late_err = 1; cyc(); idle(); rd_busy = 0;
        rd_stat(v); chk("R4 late error, no address", v, 32'hC084_0000);
        chk("R5 reserved field", {28'b0, v[23:20]}, 32'h8);
        chk("R10 irq set", {31'b0, irq}, 1);

        // R9 address-register write ignored, status write clears
        reg_sel = 1; reg_wr = 1; cyc(); idle();
        rd_stat(v); chk("R9 address write ignored", v, 32'hC084_0000);
        clear_log();
        rd_stat(v); chk("R9 clear status", v, 32'h0080_0000);
        chk("R9 irq drops", {31'b0, irq}, 0);

        // R3 error acknowledge
        issue(32'h1234_5670, 3'd5, 1);
        repeat (9) cyc();
        wr_err_ack = 1; cyc(); idle();
        rd_stat(v); chk("R3 error ack status", v, 32'h9B82_0000);
        rd_addr(v); chk("R3 error ack address", v, 32'h1234_5670);

        // R6 second fault only sets the multiple flag
        issue(32'hAAAA_0000, 3'd2, 0);
        late_err = 1; cyc(); idle();
        rd_stat(v); chk("R6 multiple flag", v, 32'h9B8A_0000);
        rd_addr(v); chk("R6 first address kept", v, 32'h1234_5670);

        // R11 normal ack ends tracking, stray ack ignored
        clear_log();
        wr_ack = 1; cyc(); idle();
        repeat (5) cyc();
        wr_ack = 1; cyc(); idle();
        repeat (TO + 5) cyc();
        rd_stat(v); chk("R11 no fault after ack", v, 32'h0080_0000);

        // R2 timeout at exactly the limit edge
        issue(32'h0BAD_F00C, 3'd3, 0);
        repeat (TO - 1) cyc();
        rd_stat(v); chk("R2 no timeout one edge early", v, 32'h0080_0000);
        cyc();
        rd_stat(v); chk("R2 timeout at limit", v, 32'hA682_0000);
        rd_addr(v); chk("R2 timeout address", v, 32'h0BAD_F00C);

        // R2 completion on the limit edge wins
        clear_log();
        issue(32'h0000_0100, 3'd1, 1);
        repeat (TO - 1) cyc();
        wr_ack = 1; cyc(); idle();
        rd_stat(v); chk("R2 ack on limit edge", v, 32'h0080_0000);

        // R7 simultaneous error ack and late error
        issue(32'h7777_0000, 3'd7, 0);
        wr_err_ack = 1; late_err = 1; cyc(); idle();
        rd_stat(v); chk("R7 priority and multiple", v, 32'h9E8A_0000);

        // R9 clear and fault in the same cycle
        reg_sel = 0; reg_wr = 1; late_err = 1; cyc(); idle();
        rd_stat(v); chk("R9 clear plus fault", v, 32'hCE82_0000);
        rd_addr(v); chk("R9 clear plus fault address", v, 32'h7777_0000);
        clear_log();

        // random phase
        for (int i = 0; i < 6000; i++) begin
            idle();
            wr_start   = ($urandom % 64) == 0;
            wr_addr    = $urandom;
            wr_size    = 3'($urandom);
            wr_super   = 1'($urandom);
            wr_ack     = ($urandom % 300) == 0;
            wr_err_ack = ($urandom % 500) == 0;
            late_err   = ($urandom % 700) == 0;
            rd_busy    = 1'($urandom);
            reg_sel    = 1'($urandom);
            reg_wr     = ($urandom % 120) == 0;
            cyc();
        end
        idle();
        cyc();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule